// File: doc/BRIEF.md
# Stoppable Pipeline Clock Generator

This block derives a local pipeline clock from a free-running oscillator model that runs in a fast reference clock domain. A half-period counter stands in for a ring of inverters and produces a raw phase square wave. The output clock is produced by a state-holding gate. It goes high only when the raw phase is high and the run condition holds. It goes low whenever the raw phase is low.

The run condition is the AND of the acknowledge lines of all attached asynchronous modules. If any module has not acknowledged when a rising edge is due, that edge is held off. While it is held, the phase counter freezes with the phase high. As soon as every acknowledge is high, the clock rises on the next reference edge and the low time that follows is never shortened. Run is needed only while a rising edge is pending. Dropping it during the high phase does not cut that phase short.

A stall counter output reports how many reference cycles the most recent rising edge was held back.

Top module: `stopclk_gen`

## Requirements
- R1: `clk_out` rises only on a reference edge at which the raw phase is high and every `ack` bit is 1. It rises one reference cycle after the raw phase goes high when run already holds.
- R2: `clk_out` returns to 0 one reference cycle after the raw phase goes low, whatever the `ack` inputs are.
- R3: After `clk_out` has risen, driving any `ack` bit low does not shorten the high time, which stays exactly the effective half period.
- R4: If run is low while a rising edge is pending, `clk_out` stays low and the raw phase stays frozen high. The clock rises at the first reference edge that samples run high, and the high time after that rise is the full effective half period.
- R5: While `rst_n` is 0, `clk_out` and `stall_cycles` are 0. After release, the first rising edge of `clk_out` comes at the reference edge numbered effective half period plus one, counted from the release.
- R6: Run is the AND of all NUM_ACK bits of `ack`. A single low bit, in any position, holds off the rising edge.
- R7: With run held high, `clk_out` is periodic, with high and low times each equal to the effective half period in reference cycles.
- R8: The effective half period is `half_period`, except that values 0 and 1 are treated as 2.
- R9: `stall_cycles` starts from zero at each new pending rising edge. It counts the reference edges at which that edge was held off, and keeps the count until the next pending edge. An edge that is not delayed leaves 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock that drives the oscillator model |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | CNT_W | Half period of the raw phase, in reference cycles |
| ack | input | NUM_ACK | Acknowledge lines, one from each asynchronous module |
| clk_out | output | 1 | Generated pipeline clock |
| stall_cycles | output | STALL_W | Reference cycles the latest rising edge was held back |

## Verification
The bound checker checks several rules on every reference cycle: the rise gating, the fall on a low phase, the high phase surviving a dropped run, the held edge with its frozen phase, the low clock just after reset, and the stall count becoming non-zero after a held cycle. Only the bench scenarios can show the numeric timing: the exact high and low times, the clamping of small half periods, the distance from reset release to the first edge, the exact stall count, and the fact that each single acknowledge bit blocks the edge on its own.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
   localparam int MIN_HALF = 2;

   typedef enum logic [1:0] {
      GATE_LOW  = 2'd0,
      GATE_WAIT = 2'd1,
      GATE_HIGH = 2'd2
   } gate_state_e;
endpackage

// File: rtl/stopclk_ack_and.sv
module stopclk_ack_and #(
   parameter int NUM_ACK = 3
) (
   input  logic [NUM_ACK-1:0] ack,
   output logic               run
);
   generate
      if (NUM_ACK == 1) begin : g_single
         assign run = ack[0];
      end else begin : g_chain
         logic [NUM_ACK:0] chain;
         assign chain[0] = 1'b1;
         for (genvar i = 0; i < NUM_ACK; i++) begin : g_stage
            assign chain[i+1] = chain[i] & ack[i];
         end
         assign run = chain[NUM_ACK];
      end
   endgenerate
endmodule

// File: rtl/stopclk_ring.sv
module stopclk_ring #(
   parameter int CNT_W = 8
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] half_period,
   input  logic             hold,
   output logic             phase
);
   localparam logic [CNT_W-1:0] MIN_HP = CNT_W'(stopclk_pkg::MIN_HALF);
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hp_eff;
   logic             terminal;

   assign hp_eff   = (half_period < MIN_HP) ? MIN_HP : half_period;
   assign terminal = (cnt_q >= (hp_eff - ONE));

   always_ff @(posedge clk_ref) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= 1'b0;
      end else if (!hold) begin
         if (terminal) begin
            cnt_q <= '0;
            phase <= ~phase;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end
endmodule

// File: rtl/stopclk_gate.sv
module stopclk_gate #(
   parameter int STALL_W = 16
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic               phase,
   input  logic               run,
   output logic               hold,
   output logic               clk_out,
   output logic [STALL_W-1:0] stall_cycles
);
   import stopclk_pkg::*;

   localparam logic [STALL_W-1:0] STALL_MAX = '1;
   localparam logic [STALL_W-1:0] STALL_ONE = STALL_W'(1);

   gate_state_e        state_q, state_d;
   logic [STALL_W-1:0] stall_d;

   assign hold    = phase && (state_q != GATE_HIGH) && !run;
   assign clk_out = (state_q == GATE_HIGH);

   always_comb begin
      if (!phase)                    state_d = GATE_LOW;
      else if (state_q == GATE_HIGH) state_d = GATE_HIGH;
      else if (run)                  state_d = GATE_HIGH;
      else                           state_d = GATE_WAIT;
   end

   always_comb begin
      stall_d = stall_cycles;
      if (phase && state_q == GATE_LOW) begin
         stall_d = run ? '0 : STALL_ONE;
      end else if (phase && state_q == GATE_WAIT && !run) begin
         stall_d = (stall_cycles == STALL_MAX) ? stall_cycles : stall_cycles + STALL_ONE;
      end
   end

   always_ff @(posedge clk_ref) begin
      if (!rst_n) begin
         state_q      <= GATE_LOW;
         stall_cycles <= '0;
      end else begin
         state_q      <= state_d;
         stall_cycles <= stall_d;
      end
   end
endmodule

// File: rtl/stopclk_gen.sv
module stopclk_gen #(
   parameter int NUM_ACK = 3,
   parameter int CNT_W   = 8,
   parameter int STALL_W = 16
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   half_period,
   input  logic [NUM_ACK-1:0] ack,
   output logic               clk_out,
   output logic [STALL_W-1:0] stall_cycles
);
   generate
      if (NUM_ACK < 1) begin : g_bad_ack
         $error("stopclk_gen: NUM_ACK must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("stopclk_gen: CNT_W must be at least 2");
      end
      if (STALL_W < 1) begin : g_bad_stall
         $error("stopclk_gen: STALL_W must be at least 1");
      end
   endgenerate

   logic run;
   logic raw_phase;
   logic hold;

   stopclk_ack_and #(.NUM_ACK(NUM_ACK)) u_and (
      .ack (ack),
      .run (run)
   );

   stopclk_ring #(.CNT_W(CNT_W)) u_ring (
      .clk_ref     (clk_ref),
      .rst_n       (rst_n),
      .half_period (half_period),
      .hold        (hold),
      .phase       (raw_phase)
   );

   stopclk_gate #(.STALL_W(STALL_W)) u_gate (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .phase        (raw_phase),
      .run          (run),
      .hold         (hold),
      .clk_out      (clk_out),
      .stall_cycles (stall_cycles)
   );
endmodule

// File: rtl/stopclk_gen_chk.sv
module stopclk_gen_chk #(
   parameter int STALL_W = 16
) (
   input logic               clk_ref,
   input logic               rst_n,
   input logic               phase,
   input logic               run,
   input logic               clk_out,
   input logic [STALL_W-1:0] stall_cycles
);
   // R1: no rise unless phase and run both high
   assert_rise_gated_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!clk_out && !(phase && run)) |=> !clk_out);

   // R2: low phase forces the clock low
   assert_low_phase_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !phase |=> !clk_out);

   // R3: high phase survives run dropping
   assert_high_kept_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (clk_out && phase) |=> clk_out);

   // R4: held edge keeps clock low and phase frozen high
   assert_held_low_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (phase && !clk_out && !run) |=> (!clk_out && phase));

   // R5: clock low right after reset release
   assert_reset_low_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(rst_n) |-> !clk_out);

   // R9: a held cycle leaves a non-zero stall count
   assert_stall_seen_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (phase && !clk_out && !run) |=> (stall_cycles != '0));
endmodule

bind stopclk_gen stopclk_gen_chk #(.STALL_W(STALL_W)) u_chk (
   .clk_ref      (clk_ref),
   .rst_n        (rst_n),
   .phase        (raw_phase),
   .run          (run),
   .clk_out      (clk_out),
   .stall_cycles (stall_cycles)
);

// File: tb/stopclk_gen_tb.sv
module stopclk_gen_tb;
   localparam int NUM_ACK = 3;
   localparam int CNT_W   = 8;
   localparam int STALL_W = 16;

   logic               clk_ref = 1'b0;
   logic               rst_n   = 1'b0;
   logic [CNT_W-1:0]   half_period = CNT_W'(4);
   logic [NUM_ACK-1:0] ack = '1;
   logic               clk_out;
   logic [STALL_W-1:0] stall_cycles;

   int checks = 0;
   int errors = 0;

   always #2.5 clk_ref = ~clk_ref;

   stopclk_gen #(.NUM_ACK(NUM_ACK), .CNT_W(CNT_W), .STALL_W(STALL_W)) u_dut (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .half_period  (half_period),
      .ack          (ack),
      .clk_out      (clk_out),
      .stall_cycles (stall_cycles)
   );

   task automatic tick();
      @(posedge clk_ref);
      #1;
   endtask

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(int hp);
      rst_n = 1'b0;
      ack = '1;
      half_period = CNT_W'(hp);
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      while (!clk_out && n < 300) begin
         tick();
         n++;
      end
   endtask

   task automatic wait_fall();
      int n = 0;
      while (clk_out && n < 300) begin
         tick();
         n++;
      end
   endtask

   task automatic meas_level(logic lvl, output int n);
      n = 0;
      while (clk_out == lvl && n < 300) begin
         n++;
         tick();
      end
   endtask

   task automatic t_reset();
      int n;
      rst_n = 1'b0;
      ack = '1;
      half_period = CNT_W'(4);
      tick();
      tick();
      tick();
      check_eq("R5", "clk_out in reset", int'(clk_out), 0);
      check_eq("R5", "stall in reset", int'(stall_cycles), 0);
      rst_n = 1'b1;
      wait_rise(n);
      check_eq("R5", "edges to first rise", n, 5);
   endtask

   task automatic t_period(int hp, int exp_hp, string req);
      int n;
      do_reset(hp);
      wait_rise(n);
      meas_level(1'b1, n);
      check_eq(req, "high time", n, exp_hp);
      meas_level(1'b0, n);
      check_eq(req, "low time", n, exp_hp);
      meas_level(1'b1, n);
      check_eq("R7", "second high time", n, exp_hp);
      check_eq("R9", "stall without hold", int'(stall_cycles), 0);
   endtask

   task automatic t_stall();
      int n;
      int bad = 0;
      do_reset(4);
      wait_rise(n);
      ack[1] = 1'b0;
      meas_level(1'b1, n);
      check_eq("R3", "high time with run dropped", n, 4);
      for (int k = 0; k < 20; k++) begin
         tick();
         if (clk_out) bad++;
      end
      check_eq("R4", "highs while held", bad, 0);
      ack = '1;
      tick();
      check_eq("R4", "rise right after run", int'(clk_out), 1);
      check_eq("R9", "stall count", int'(stall_cycles), 17);
      meas_level(1'b1, n);
      check_eq("R4", "high time after restart", n, 4);
      check_eq("R9", "stall held until next edge", int'(stall_cycles), 17);
   endtask

   task automatic t_each_ack();
      int n;
      do_reset(3);
      wait_rise(n);
      for (int i = 0; i < NUM_ACK; i++) begin
         int bad = 0;
         wait_fall();
         ack[i] = 1'b0;
         for (int k = 0; k < 9; k++) begin
            tick();
            if (clk_out) bad++;
         end
         check_eq("R6", $sformatf("highs while ack[%0d] low", i), bad, 0);
         ack = '1;
         tick();
         check_eq("R6", $sformatf("rise after ack[%0d] back", i), int'(clk_out), 1);
      end
   endtask

   initial begin
      t_reset();
      t_period(4, 4, "R7");
      t_period(7, 7, "R7");
      t_period(1, 2, "R8");
      t_period(0, 2, "R8");
      t_stall();
      t_each_ack();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_ref);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule